// File: doc/BRIEF.md
# Packed Register-Write Stream Decoder

This block sits between a command-fetch engine and a register write port. The fetch engine supplies a stream of 32-bit words with a valid/ready handshake. The block cuts the stream into packets of five words. The first word of a packet is a header that holds four compact register indices, one per byte. Each of the next four words is the data value for one of those indices.

For every data word the block turns the matching index into a byte address in one of two register banks. It then issues one write on a simple enable/address/data port. When the write port stalls, the block holds the pending write steady and drops its ready signal, so no word is lost. A one-cycle completion pulse follows the last write of each packet. Software or an upstream packer can therefore send four writes for the cost of five words, where plain address/data pairs would need eight.

Top module: `regstream_unpacker`

## Requirements
- R1: A synchronous reset clears `wr_en` and `pkt_done`, raises `in_ready`, and makes the next accepted word a header, even if the reset arrives in the middle of a packet.
- R2: Each packet is exactly five accepted words. The header word produces no write, and the cycle after a header is accepted `wr_en` is low.
- R3: Data words are paired with header bytes in order: data word 1 with bits 7:0, word 2 with bits 15:8, word 3 with bits 23:16 and word 4 with bits 31:24. Writes come out in that order.
- R4: An index whose bit 7 is 0 maps to byte address 0x1C00 + index*4, which covers 0x1C00 to 0x1DFC.
- R5: An index whose bit 7 is 1 maps to byte address 0x2C00 + (index & 0x7F)*4, which covers 0x2C00 to 0x2DFC.
- R6: Every issued write address has its two low bits at zero and lies in one of the two bank ranges.
- R7: A data word accepted at a clock edge appears on `wr_en`/`wr_addr`/`wr_data` in the cycle right after that edge, with `wr_data` equal to the word.
- R8: While `wr_en` and `wr_stall` are both high, `in_ready` is low and the write stays unchanged into the next cycle. After stalls, every data word still comes out exactly once and in order.
- R9: `pkt_done` is high for exactly one cycle, in the cycle after the fourth write of a packet is issued (issued means `wr_en` high with `wr_stall` low).
- R10: Packets can follow one another with no idle cycles, with one word accepted every cycle when there is no stall.

Port table:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 32 | Input stream word (header or data) |
| in_ready | output | 1 | Block can accept a word this cycle |
| wr_stall | input | 1 | Write port cannot take the current write |
| wr_en | output | 1 | Write request |
| wr_addr | output | 16 | Byte address of the write |
| wr_data | output | 32 | Write data |
| pkt_done | output | 1 | One-cycle pulse after a packet's fourth write |

## Verification
A wrong framing count shows up at the ports within one packet: either a header word is issued as data, with an address taken from the wrong header byte, or `pkt_done` fires after the wrong write. A wrong lane select or bank decode shows up on the very next write as an address that differs from the value computed from the header byte. A faulty hold path shows up within one stalled cycle, as a changed address or data while stalled, or as a word that goes missing from the captured write sequence once the packet ends.

// File: rtl/regstream_pkg.sv
package regstream_pkg;
  parameter int unsigned IDX_W  = 8;
  parameter int unsigned ADDR_W = 16;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [ADDR_W-1:0] addr_t;

  // Top index bit picks the bank; remaining bits give a word offset.
  function automatic addr_t idx_to_addr(input idx_t idx, input addr_t bank0,
                                        input addr_t bank1);
    addr_t off;
    off = addr_t'(idx[IDX_W-2:0]) << 2;
    return (idx[IDX_W-1] ? bank1 : bank0) + off;
  endfunction
endpackage

// File: rtl/rsu_framer.sv
module rsu_framer #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned SLOT_W = $clog2(LANES + 1),
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  output logic [DATA_W-1:0] header,
  output logic              is_hdr,
  output logic [LANE_W-1:0] lane,
  output logic              last
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(LANES);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] slot_m1;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot   <= '0;
      header <= '0;
    end else if (accept) begin
      if (slot == '0) header <= in_data;
      slot <= (slot == LAST_SLOT) ? '0 : slot + SLOT_W'(1);
    end
  end

  assign slot_m1 = slot - SLOT_W'(1);
  assign is_hdr  = (slot == '0);
  assign lane    = slot_m1[LANE_W-1:0];
  assign last    = (slot == LAST_SLOT);
endmodule

// File: rtl/rsu_lane_decode.sv
module rsu_lane_decode
  import regstream_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 16'h1C00,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 16'h2C00,
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DATA_W-1:0] header,
  input  logic [LANE_W-1:0] lane,
  output addr_t             addr
);
  addr_t lane_addr [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_addr[l] = idx_to_addr(header[l*IDX_W +: IDX_W], BANK0_BASE, BANK1_BASE);
  end

  assign addr = lane_addr[lane];
endmodule

// File: rtl/rsu_write_stage.sv
module rsu_write_stage
  import regstream_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  addr_t             load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_last,
  input  logic              wr_stall,
  output logic              hold,
  output logic              wr_en,
  output addr_t             wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              pkt_done
);
  logic last_q;

  assign hold = wr_en && wr_stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      last_q   <= 1'b0;
      pkt_done <= 1'b0;
    end else begin
      pkt_done <= wr_en && !wr_stall && last_q;
      if (!hold) begin
        wr_en <= load;
        if (load) begin
          wr_addr <= load_addr;
          wr_data <= load_data;
          last_q  <= load_last;
        end else begin
          last_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/regstream_unpacker.sv
module regstream_unpacker
  import regstream_pkg::*;
#(
  parameter int unsigned LANES      = 4,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 16'h1C00,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 16'h2C00,
  localparam int unsigned DATA_W = LANES * IDX_W,
  localparam int unsigned LANE_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic              wr_stall,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              pkt_done
);
  // Named internal events, visible to the bound checker.
  logic              accept;
  logic              hdr_accept;
  logic              data_accept;
  logic              hold;
  logic [DATA_W-1:0] header;
  logic              is_hdr;
  logic              last;
  logic [LANE_W-1:0] lane;
  addr_t             lane_addr;

  assign in_ready    = !hold;
  assign accept      = in_valid && in_ready;
  assign hdr_accept  = accept && is_hdr;
  assign data_accept = accept && !is_hdr;

  rsu_framer #(.LANES(LANES), .DATA_W(DATA_W)) u_framer (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .in_data(in_data),
    .header (header),
    .is_hdr (is_hdr),
    .lane   (lane),
    .last   (last)
  );

  rsu_lane_decode #(
    .LANES(LANES), .DATA_W(DATA_W),
    .BANK0_BASE(BANK0_BASE), .BANK1_BASE(BANK1_BASE)
  ) u_decode (
    .header(header),
    .lane  (lane),
    .addr  (lane_addr)
  );

  rsu_write_stage #(.DATA_W(DATA_W)) u_wr (
    .clk      (clk),
    .rst      (rst),
    .load     (data_accept),
    .load_addr(lane_addr),
    .load_data(in_data),
    .load_last(last),
    .wr_stall (wr_stall),
    .hold     (hold),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pkt_done (pkt_done)
  );
endmodule

// File: rtl/regstream_unpacker_chk.sv
module regstream_unpacker_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BANK0_BASE = 16'h1C00,
  parameter logic [ADDR_W-1:0] BANK1_BASE = 16'h2C00,
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(16'h01FC)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              wr_stall,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              pkt_done,
  input logic              hdr_accept
);
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_stall) |-> !in_ready); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_stall) |=> (wr_en && $stable(wr_addr) && $stable(wr_data))); // R8
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr[1:0] == 2'b00)); // R6
  AST_ADDR_IN_BANK: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ((wr_addr >= BANK0_BASE && wr_addr <= BANK0_BASE + SPAN) ||
               (wr_addr >= BANK1_BASE && wr_addr <= BANK1_BASE + SPAN))); // R6
  AST_HDR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    hdr_accept |=> !wr_en); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pkt_done |=> !pkt_done); // R9
  AST_DONE_AFTER_ISSUE: assert property (@(posedge clk) disable iff (rst)
    $rose(pkt_done) |-> $past(wr_en && !wr_stall)); // R9
endmodule

bind regstream_unpacker regstream_unpacker_chk #(
  .DATA_W(DATA_W), .ADDR_W(regstream_pkg::ADDR_W),
  .BANK0_BASE(BANK0_BASE), .BANK1_BASE(BANK1_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_ready  (in_ready),
  .wr_stall  (wr_stall),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .pkt_done  (pkt_done),
  .hdr_accept(hdr_accept)
);

// File: tb/test_regstream_unpacker.sv
`timescale 1ns/1ps
module test_regstream_unpacker;
  localparam int CLK_PERIOD = 10;
  localparam int NPKT = 4;
  localparam int WDOG = 50000;
  // Five words per packet: header then four data words.
  localparam logic [31:0] STIM [0:NPKT*5-1] = '{
    32'h0302_0100, 32'hAAAA_0001, 32'hAAAA_0002, 32'hAAAA_0003, 32'hAAAA_0004,
    32'hFF80_7F00, 32'hBBBB_0001, 32'hBBBB_0002, 32'hBBBB_0003, 32'hBBBB_0004,
    32'h8155_2A91, 32'hCCCC_0001, 32'hCCCC_0002, 32'hCCCC_0003, 32'hCCCC_0004,
    32'h0102_0304, 32'hDDDD_0001, 32'hDDDD_0002, 32'hDDDD_0003, 32'hDDDD_0004
  };

  logic clk = 0, rst = 1, in_valid = 0, wr_stall = 0, stall_en = 0;
  logic [31:0] in_data = '0;
  logic in_ready, wr_en, pkt_done;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic [7:0] lfsr = 8'h5A;

  int checks = 0, failures = 0, cycles = 0;
  logic [15:0] cap_addr [0:63];
  logic [31:0] cap_data [0:63];
  logic [15:0] exp_addr [0:63];
  logic [31:0] exp_data [0:63];
  int cap_n = 0, exp_n = 0, wcount = 0;
  logic done_due = 0, held = 0;
  logic [15:0] held_addr;
  logic [31:0] held_data;
  logic [31:0] cur_hdr;
  int lane_n = 0;

  regstream_unpacker i_regstream_unpacker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .wr_stall(wr_stall), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pkt_done(pkt_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    wr_stall <= stall_en && lfsr[0];
  end

  function automatic logic [15:0] bench_addr(input logic [7:0] idx);
    if (idx < 8'd128) return 16'h1C00 + 16'(idx) * 16'd4;
    return 16'h2C00 + 16'(idx - 8'd128) * 16'd4;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor, sampled on the falling edge.
  always @(negedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      check(0, "WATCHDOG", cycles, WDOG);
      finish_run();
    end
    if (rst) begin
      wcount = 0; done_due = 0; held = 0;
    end else begin
      check(pkt_done == done_due, "R9 done timing", pkt_done, done_due);
      if (held)
        check(wr_en && wr_addr == held_addr && wr_data == held_data,
              "R8 held write", wr_data, held_data);
      done_due = 0;
      held = 0;
      if (wr_en && wr_stall) begin
        check(!in_ready, "R8 ready low", in_ready, 0);
        held = 1; held_addr = wr_addr; held_data = wr_data;
      end
      if (wr_en && !wr_stall) begin
        if (cap_n < 64) begin
          cap_addr[cap_n] = wr_addr; cap_data[cap_n] = wr_data;
        end
        cap_n++;
        wcount++;
        if (wcount == 4) begin done_due = 1; wcount = 0; end
      end
    end
  end

  task automatic send(input logic [31:0] w);
    bit acc;
    in_valid = 1; in_data = w;
    if (lane_n == 0) cur_hdr = w;
    else begin
      exp_addr[exp_n] = bench_addr(cur_hdr[(lane_n-1)*8 +: 8]);
      exp_data[exp_n] = w;
      exp_n++;
    end
    lane_n = (lane_n == 4) ? 0 : lane_n + 1;
    forever begin
      acc = in_ready;
      @(posedge clk); @(negedge clk);
      if (acc) break;
    end
  endtask

  task automatic compare(input string req);
    check(cap_n == exp_n, {req, " count"}, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      check(cap_addr[i] == exp_addr[i] && cap_data[i] == exp_data[i], req,
            {cap_addr[i], cap_data[i][15:0]}, {exp_addr[i], exp_data[i][15:0]});
  endtask

  task automatic clear_log();
    cap_n = 0; exp_n = 0; lane_n = 0;
  endtask

  task automatic idle(input int n);
    in_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int t0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    check(!wr_en && !pkt_done && in_ready, "R1 reset state",
          {wr_en, pkt_done, in_ready}, 3'b001);

    // R3 R4 R5 R10: table walked back to back, no stall
    t0 = cycles;
    for (int i = 0; i < NPKT*5; i++) send(STIM[i]);
    check(cycles - t0 == NPKT*5, "R10 one word per cycle", cycles - t0, NPKT*5);
    idle(4);
    compare("R3 table writes");
    // Bank boundaries from packet 1 (R4, R5)
    check(cap_addr[5] == 16'h1DFC, "R4 bank0 top", cap_addr[5], 16'h1DFC);
    check(cap_addr[4] == 16'h1C00, "R4 bank0 base", cap_addr[4], 16'h1C00);
    check(cap_addr[6] == 16'h2C00, "R5 bank1 base", cap_addr[6], 16'h2C00);
    check(cap_addr[7] == 16'h2DFC, "R5 bank1 top", cap_addr[7], 16'h2DFC);
    check(cap_addr[8] == 16'h2C44, "R5 bank1 mid", cap_addr[8], 16'h2C44);
    clear_log();

    // R2 R7: single words with gaps
    send(32'h0000_0A85);
    idle(1);
    check(!wr_en, "R2 header gives no write", wr_en, 0);
    send(32'h1234_5678);
    check(wr_en && wr_data == 32'h1234_5678 && wr_addr == 16'h2C14,
          "R7 write next cycle", wr_data, 32'h1234_5678);
    idle(2);
    for (int k = 0; k < 3; k++) send(32'h9000_0000 + k);
    idle(3);
    compare("R2 gapped packet");
    clear_log();

    // R8: random stalls
    stall_en = 1;
    for (int i = 0; i < 15; i++) send(STIM[i + 5]);
    idle(20);
    stall_en = 0;
    idle(4);
    compare("R8 stalled stream");
    clear_log();

    // R1: reset in the middle of a packet
    send(32'h0403_0201); send(32'h1111_1111); send(32'h2222_2222);
    in_valid = 0;
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
    check(!wr_en && in_ready, "R1 mid-packet reset", {wr_en, in_ready}, 2'b01);
    clear_log();
    send(32'h8584_8382);
    for (int k = 0; k < 4; k++) send(32'h5000_0000 + k);
    idle(4);
    compare("R1 reframe after reset");

    finish_run();
  end
endmodule